// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block takes a single asynchronous serial input line and turns it into bytes. Each frame has a low start bit, eight data bits sent least significant bit first, an optional parity bit, and one stop bit. Bit timing comes from a clock-enable pulse that the surrounding logic supplies at sixteen times the bit rate. The receiver passes the line through a two-flop synchronizer. It waits for a falling edge and confirms the start bit half a bit later. It then samples every later bit at its centre.

A finished frame updates a small register port. One register holds the last accepted byte. The other is a status register with five fields: the data-ready flag, three sticky error flags (overrun, parity, framing) and the live synchronized line level. Software reads the status and the byte, then clears flags by writing zeros. While any error flag is set, the receiver ignores the line completely, so software must handle an error before reception can resume. Two interrupt requests, one for data and one for errors, are gated by a single enable input.

The frame state machine has five states: `ST_IDLE`, `ST_START`, `ST_DATA`, `ST_PARITY` and `ST_STOP`. Its transitions are:

| Transition | Condition |
|---|---|
| idle→start | falling edge while not blocked |
| start→data | confirmed low at mid-bit |
| start→idle | glitch |
| data→data | next bit |
| data→parity | last bit, parity on |
| data→stop | last bit, parity off |
| parity→stop | parity bit sampled |
| stop→idle | stop bit sampled, frame complete |

Top module: `arx_receiver`

## Requirements
- R1: After reset, the status register (select 0) reads 0x10 with an idle-high line. The data register (select 1) reads 0x00, and both interrupt requests are low.
- R2: Bit 4 of the status register shows the RX line level after a two-flop synchronizer. It reads 0 during a break and 1 when the line is idle.
- R3: A falling edge starts a frame only if the line is still low 8 sampling ticks later. Otherwise the receiver returns to idle and no flag or data changes.
- R4: In a valid frame, the data bits are taken every 16 ticks at mid-bit, least significant first. The byte is loaded into the data register and status bit 0 (data ready) becomes 1.
- R5: With parity enabled, one parity bit follows the data. In even mode (odd select 0) the data bits plus the parity bit hold an even number of ones; in odd mode they hold an odd number. A mismatch sets status bit 2 and the byte is not stored.
- R6: A stop bit sampled as 0 sets status bit 3 (framing error) and the byte is not stored.
- R7: A frame that completes while bit 0 is still 1 sets status bit 1 (overrun). The data register keeps its old byte and bit 0 stays 1.
- R8: A write with select 0 clears each of status bits 0 to 3 whose written bit is 0. Written 1s have no effect, and writes with select 1 are ignored. Error flags change only on such a clear or on a completed frame.
- R9: While any of status bits 1 to 3 is 1, no frame is started, and the data register and bit 0 stay unchanged.
- R10: The data interrupt equals bit 0 AND the interrupt enable. The error interrupt equals (bit 1 OR bit 2 OR bit 3) AND the interrupt enable.
- R11: An overrun takes precedence: when bit 0 is 1 at frame end, only bit 1 is set, even if the stop or parity bit is bad. Parity and framing errors may be set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| os_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| cfg_par_en_i | input | 1 | Expect a parity bit after the data |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| cfg_rie_i | input | 1 | Enables both interrupt requests |
| reg_sel_i | input | 1 | 0 selects status, 1 selects data |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |
| irq_rxd_o | output | 1 | Data-ready interrupt request |
| irq_err_o | output | 1 | Receive-error interrupt request |

## Verification
The assertions assume two things about the inputs. First, the configuration inputs do not change while a frame is in flight. Second, the only thing that changes the status flags between frames is a select-0 write. The stimulus changes parity mode and interrupt enable only while the line has been idle for at least a bit time. It issues writes only between frames, and it drives the line in whole bit periods of 32 clocks, with a tick every second clock. The one exception is the deliberate glitch, which is kept shorter than half a bit.

// File: rtl/arx_pkg.sv
package arx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } arx_state_e;

    localparam int unsigned STAT_FULL = 0;
    localparam int unsigned STAT_OVR  = 1;
    localparam int unsigned STAT_PER  = 2;
    localparam int unsigned STAT_FER  = 3;
    localparam int unsigned STAT_LINE = 4;

endpackage

// File: rtl/arx_sync.sv
module arx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_i,
    output logic rx_s_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= rx_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b1;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rx_s_o = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/arx_frame_fsm.sv
module arx_frame_fsm
    import arx_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rx_s_i,
    input  logic              fall_i,
    input  logic              blocked_i,
    input  logic              par_en_i,
    input  logic              par_odd_i,
    output logic              done_o,
    output logic [DATA_W-1:0] byte_o,
    output logic              par_ok_o,
    output logic              stop_ok_o
);
    localparam int unsigned CNT_W = $clog2(OVS);
    localparam int unsigned IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

    arx_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    logic              par_q;
    logic              half_hit, full_hit;

    assign half_hit = tick_i && (cnt_q == HALF);
    assign full_hit = tick_i && (cnt_q == LAST);

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (fall_i && !blocked_i) state_d = ST_START;
            ST_START:  if (half_hit) state_d = rx_s_i ? ST_IDLE : ST_DATA;
            ST_DATA:   if (full_hit && idx_q == TOP)
                           state_d = par_en_i ? ST_PARITY : ST_STOP;
            ST_PARITY: if (full_hit) state_d = ST_STOP;
            ST_STOP:   if (full_hit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shift_q <= '0;
            par_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: cnt_q <= '0;
                ST_START: begin
                    if (half_hit) begin
                        cnt_q <= '0;
                        idx_q <= '0;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA: begin
                    if (full_hit) begin
                        cnt_q   <= '0;
                        shift_q <= {rx_s_i, shift_q[DATA_W-1:1]};
                        idx_q   <= idx_q + 1'b1;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PARITY: begin
                    if (full_hit) begin
                        cnt_q <= '0;
                        par_q <= rx_s_i;
                    end else if (tick_i) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (full_hit)    cnt_q <= '0;
                    else if (tick_i) cnt_q <= cnt_q + 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        done_o    = (state_q == ST_STOP) && full_hit;
        byte_o    = shift_q;
        stop_ok_o = rx_s_i;
        par_ok_o  = !par_en_i || ((^shift_q ^ par_q) == par_odd_i);
    end
endmodule

// File: rtl/arx_status_regs.sv
module arx_status_regs
    import arx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              par_ok_i,
    input  logic              stop_ok_i,
    input  logic              wr_i,
    input  logic              sel_i,
    input  logic [3:0]        clr_n_i,
    input  logic              rie_i,
    output logic              full_o,
    output logic              ovr_o,
    output logic              per_o,
    output logic              fer_o,
    output logic [DATA_W-1:0] data_o,
    output logic              err_any_o,
    output logic              irq_rxd_o,
    output logic              irq_err_o
);
    logic              full_d, ovr_d, per_d, fer_d;
    logic [DATA_W-1:0] data_d;
    logic              stat_wr;

    assign stat_wr   = wr_i && !sel_i;
    assign err_any_o = ovr_o | per_o | fer_o;

    always_comb begin
        full_d = full_o;
        ovr_d  = ovr_o;
        per_d  = per_o;
        fer_d  = fer_o;
        data_d = data_o;
        if (stat_wr) begin
            if (!clr_n_i[STAT_FULL]) full_d = 1'b0;
            if (!clr_n_i[STAT_OVR])  ovr_d  = 1'b0;
            if (!clr_n_i[STAT_PER])  per_d  = 1'b0;
            if (!clr_n_i[STAT_FER])  fer_d  = 1'b0;
        end
        if (done_i && !err_any_o) begin
            if (full_o) begin
                ovr_d = 1'b1;
            end else if (!stop_ok_i || !par_ok_i) begin
                if (!stop_ok_i) fer_d = 1'b1;
                if (!par_ok_i)  per_d = 1'b1;
            end else begin
                data_d = byte_i;
                full_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_o <= 1'b0;
            ovr_o  <= 1'b0;
            per_o  <= 1'b0;
            fer_o  <= 1'b0;
            data_o <= '0;
        end else begin
            full_o <= full_d;
            ovr_o  <= ovr_d;
            per_o  <= per_d;
            fer_o  <= fer_d;
            data_o <= data_d;
        end
    end

    assign irq_rxd_o = full_o && rie_i;
    assign irq_err_o = err_any_o && rie_i;
endmodule

// File: rtl/arx_receiver.sv
module arx_receiver
    import arx_pkg::*;
#(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned OVS     = 16,
    parameter int unsigned SYNC_ST = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_i,
    input  logic              os_tick_i,
    input  logic              cfg_par_en_i,
    input  logic              cfg_par_odd_i,
    input  logic              cfg_rie_i,
    input  logic              reg_sel_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_rxd_o,
    output logic              irq_err_o
);
    logic              rx_s, fall;
    logic              done, par_ok, stop_ok;
    logic [DATA_W-1:0] rx_byte;
    logic              st_full, st_ovr, st_per, st_fer, err_any;
    logic [DATA_W-1:0] st_data;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata_i[DATA_W-1:4];

    arx_sync #(.STAGES(SYNC_ST)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rx_i   (rx_i),
        .rx_s_o (rx_s),
        .fall_o (fall)
    );

    arx_frame_fsm #(.DATA_W(DATA_W), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (os_tick_i),
        .rx_s_i    (rx_s),
        .fall_i    (fall),
        .blocked_i (err_any),
        .par_en_i  (cfg_par_en_i),
        .par_odd_i (cfg_par_odd_i),
        .done_o    (done),
        .byte_o    (rx_byte),
        .par_ok_o  (par_ok),
        .stop_ok_o (stop_ok)
    );

    arx_status_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done),
        .byte_i    (rx_byte),
        .par_ok_i  (par_ok),
        .stop_ok_i (stop_ok),
        .wr_i      (reg_wr_i),
        .sel_i     (reg_sel_i),
        .clr_n_i   (reg_wdata_i[3:0]),
        .rie_i     (cfg_rie_i),
        .full_o    (st_full),
        .ovr_o     (st_ovr),
        .per_o     (st_per),
        .fer_o     (st_fer),
        .data_o    (st_data),
        .err_any_o (err_any),
        .irq_rxd_o (irq_rxd_o),
        .irq_err_o (irq_err_o)
    );

    always_comb begin
        if (reg_sel_i) reg_rdata_o = st_data;
        else           reg_rdata_o = {{(DATA_W-5){1'b0}}, rx_s, st_fer, st_per, st_ovr, st_full};
    end
endmodule

// File: rtl/arx_receiver_chk.sv
module arx_receiver_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_i,
    input logic              reg_sel_i,
    input logic [DATA_W-1:0] reg_wdata_i,
    input logic              done,
    input logic              st_full,
    input logic              st_ovr,
    input logic              st_per,
    input logic              st_fer,
    input logic [DATA_W-1:0] st_data
);
    logic clr_ovr, clr_fer;
    assign clr_ovr = reg_wr_i && !reg_sel_i && !reg_wdata_i[1];
    assign clr_fer = reg_wr_i && !reg_sel_i && !reg_wdata_i[3];

    AST_STICKY_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        st_ovr && !clr_ovr |=> st_ovr); // R8
    AST_STICKY_FER: assert property (@(posedge clk) disable iff (!rst_n)
        st_fer && !clr_fer |=> st_fer); // R8
    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_ovr) |-> $stable(st_data) && st_full); // R7
    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_ovr || st_per || st_fer) |=> $stable(st_data)); // R9
    AST_FULL_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_full) |-> $past(done)); // R4
    AST_FER_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_fer) |-> $past(done)); // R6
endmodule

bind arx_receiver arx_receiver_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .done        (done),
    .st_full     (st_full),
    .st_ovr      (st_ovr),
    .st_per      (st_per),
    .st_fer      (st_fer),
    .st_data     (st_data)
);

// File: tb/test_arx_receiver.sv
`timescale 1ns/1ps
module test_arx_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx = 1'b1;
    logic       tick = 1'b0;
    logic       par_en = 1'b0, par_odd = 1'b0, rie = 1'b0;
    logic       sel_auto = 1'b0, sel_man = 1'b0, hold = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq_rxd, irq_err;
    logic       sel;

    int total = 0, bad = 0, cyc = 0;

    assign sel = hold ? sel_man : sel_auto;

    always #5 clk = ~clk;

    arx_receiver i_arx_receiver (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_i          (rx),
        .os_tick_i     (tick),
        .cfg_par_en_i  (par_en),
        .cfg_par_odd_i (par_odd),
        .cfg_rie_i     (rie),
        .reg_sel_i     (sel),
        .reg_wr_i      (wr),
        .reg_wdata_i   (wdata),
        .reg_rdata_o   (rdata),
        .irq_rxd_o     (irq_rxd),
        .irq_err_o     (irq_err)
    );

    always @(negedge clk) begin
        tick     <= ~tick;
        sel_auto <= ~sel_auto;
    end

    // behavioural reference model
    int         ph, mc, nb;
    logic [7:0] msh, mdata;
    logic       mpar, ms1, ms2, mprev;
    logic       mfull, movr, mper, mfer;

    always @(posedge clk) begin
        logic done, sok, pok, blocked;
        if (!rst_n) begin
            ph = 0; mc = 0; nb = 0; msh = 0; mdata = 0; mpar = 0;
            ms1 = 1; ms2 = 1; mprev = 1;
            mfull = 0; movr = 0; mper = 0; mfer = 0;
        end else begin
            done = 0; sok = 1; pok = 1;
            blocked = movr | mper | mfer;
            case (ph)
                0: if (mprev && !ms2 && !blocked) begin ph = 1; mc = 0; end
                1: if (tick) begin
                       if (mc == 7) begin
                           if (!ms2) begin ph = 2; mc = 0; nb = 0; end else ph = 0;
                       end else mc++;
                   end
                2: if (tick) begin
                       if (mc == 15) begin
                           msh[nb] = ms2; mc = 0;
                           if (nb == 7) ph = par_en ? 3 : 4; else nb++;
                       end else mc++;
                   end
                3: if (tick) begin
                       if (mc == 15) begin mpar = ms2; mc = 0; ph = 4; end else mc++;
                   end
                default: if (tick) begin
                       if (mc == 15) begin
                           done = 1; sok = ms2;
                           pok = !par_en || ((^msh ^ mpar) == par_odd);
                           ph = 0; mc = 0;
                       end else mc++;
                   end
            endcase
            begin
                logic old_full;
                old_full = mfull;
                if (wr && !sel) begin
                    if (!wdata[0]) mfull = 0;
                    if (!wdata[1]) movr = 0;
                    if (!wdata[2]) mper = 0;
                    if (!wdata[3]) mfer = 0;
                end
                if (done && !blocked) begin
                    if (old_full) movr = 1;
                    else if (!sok || !pok) begin
                        if (!sok) mfer = 1;
                        if (!pok) mper = 1;
                    end else begin mdata = msh; mfull = 1; end
                end
            end
            mprev = ms2; ms2 = ms1; ms1 = rx;
        end
    end

    task automatic cmp(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (sel) cmp("R4 data register", rdata, mdata);
            else begin
                cmp("R4 ready flag", rdata[0], mfull);
                cmp("R7 overrun flag", rdata[1], movr);
                cmp("R5 parity flag", rdata[2], mper);
                cmp("R6 framing flag", rdata[3], mfer);
                cmp("R2 line level", rdata[4], ms2);
                cmp("R1 upper status bits", rdata[7:5], 0);
            end
            cmp("R10 data irq", irq_rxd, mfull & rie);
            cmp("R10 error irq", irq_err, (movr | mper | mfer) & rie);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
            $finish;
        end
    end

    task automatic rd(input logic s, output logic [7:0] v);
        @(negedge clk); hold = 1; sel_man = s;
        @(posedge clk); #2; v = rdata;
        @(negedge clk); hold = 0;
    endtask

    task automatic wr_reg(input logic s, input logic [7:0] v);
        @(negedge clk); hold = 1; sel_man = s; wr = 1; wdata = v;
        @(negedge clk); wr = 0; hold = 0;
    endtask

    task automatic bit_out(input logic b);
        rx = b;
        repeat (32) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic bad_par, input logic stop);
        logic p;
        @(negedge clk);
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        if (par_en) begin
            p = par_odd ? ~^d : ^d;
            bit_out(p ^ bad_par);
        end
        bit_out(stop);
        rx = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd(0, v); cmp("R1 reset status", v, 8'h10);
        rd(1, v); cmp("R1 reset data", v, 8'h00);
        cmp("R1 reset irqs", {irq_rxd, irq_err}, 0);
        rie = 1'b1;

        send(8'hA5, 0, 1);
        rd(1, v); cmp("R4 byte A5", v, 8'hA5);
        rd(0, v); cmp("R4 ready set", v, 8'h11);
        cmp("R10 data irq high", irq_rxd, 1);
        wr_reg(0, 8'hFE);
        rd(0, v); cmp("R8 ready cleared", v, 8'h10);

        // glitch shorter than half a bit
        @(negedge clk); rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
        repeat (400) @(negedge clk);
        rd(0, v); cmp("R3 glitch no flags", v, 8'h10);
        rd(1, v); cmp("R3 glitch data kept", v, 8'hA5);

        par_en = 1'b1; par_odd = 1'b0;
        send(8'h3C, 0, 1);
        rd(1, v); cmp("R5 even parity byte", v, 8'h3C);
        wr_reg(0, 8'hFE);
        par_odd = 1'b1;
        send(8'h01, 0, 1);
        rd(1, v); cmp("R5 odd parity byte", v, 8'h01);
        wr_reg(0, 8'hFE);
        par_odd = 1'b0;
        send(8'h55, 1, 1);
        rd(0, v); cmp("R5 parity error flag", v, 8'h14);
        rd(1, v); cmp("R5 byte not stored", v, 8'h01);
        cmp("R10 error irq high", irq_err, 1);

        send(8'h77, 0, 1);
        rd(0, v); cmp("R9 blocked status", v, 8'h14);
        rd(1, v); cmp("R9 blocked data", v, 8'h01);

        wr_reg(0, 8'hFF);
        rd(0, v); cmp("R8 ones no effect", v, 8'h14);
        wr_reg(1, 8'h99);
        rd(1, v); cmp("R8 data write ignored", v, 8'h01);
        wr_reg(0, 8'hFB);
        rd(0, v); cmp("R8 parity cleared", v, 8'h10);

        par_en = 1'b0;
        send(8'h12, 0, 0);
        rd(0, v); cmp("R6 framing flag", v, 8'h18);
        @(negedge clk); rx = 1'b0; repeat (40) @(negedge clk);
        rd(0, v); cmp("R2 break level", v, 8'h08);
        rx = 1'b1; repeat (40) @(negedge clk);
        wr_reg(0, 8'hF7);
        rd(0, v); cmp("R8 framing cleared", v, 8'h10);

        send(8'h21, 0, 1);
        send(8'h42, 0, 0);
        rd(0, v); cmp("R11 overrun only", v, 8'h13);
        rd(1, v); cmp("R7 old byte kept", v, 8'h21);

        wr_reg(0, 8'hF0);
        rie = 1'b0;
        send(8'h66, 0, 1);
        rd(1, v); cmp("R4 byte 66", v, 8'h66);
        cmp("R10 irq masked", irq_rxd, 0);

        repeat (10) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
        $finish;
    end
endmodule